// File: doc/BRIEF.md
# UART Interrupt Identification and Priority Unit

This unit collects every interrupt event of a single UART channel, holds each event as a pending flag, and picks the most urgent enabled one. It reports that choice as an eight-bit read-only identification value and drives one interrupt line. The events come from other parts of the channel as levels or one-cycle strobes. These parts are the line-error flags, the receive FIFO occupancy and its trigger threshold, a per-bit-time tick, transmit-holding-empty, the modem input lines, flow-control character matches, and the CTS and RTS pins. The FIFOs, serializer and bus decode sit outside and are represented only by these strobes.

Each source is cleared by its own register access or data event. A source that an identification read is allowed to clear is cleared only when that same read reported it. A read that returns a more urgent source therefore never drops a less urgent one. The receive timeout is counted here, from bit-time ticks, while data waits in the FIFO and nothing touches it.

Top module: `uart_int_ident`

## Requirements
- R1: After reset `iirValue` is 8'h01 and `irqOut` is 0. At all times `irqOut` is the inverse of `iirValue[0]`, and `iirValue[0]` is 0 exactly when an enabled source is pending.
- R2: `iirValue[7:6]` reads 2'b11 while `fifoEn` is 1 and 2'b00 while it is 0.
- R3: `iirValue[5:0]` codes are 6'b000110 for line status, 6'b001100 for receive timeout, 6'b000100 for receive data, 6'b000010 for transmit empty, 6'b000000 for modem status, 6'b010000 for Xoff/special character, 6'b100000 for CTS/RTS edge, and 6'b000001 for none.
- R4: Priority, most urgent first, is line status, then receive timeout, then receive data, then transmit empty, modem status, Xoff/special character, and CTS/RTS edge.
- R5: `srcEnable` gates the sources by bit position: 0 line status, 1 timeout, 2 receive data, 3 transmit empty, 4 modem, 5 Xoff/special, 6 CTS/RTS. A disabled source neither shows in `iirValue` nor raises `irqOut`. Its pending flag is kept and appears once the source is enabled.
- R6: A line-status source is pending in the cycle after any `lineErr` bit is 1. It stays pending until an `lsrRead` occurs while `lineErr` is all zero.
- R7: A receive-data source is pending while `rxLevel` is nonzero and at least `rxTrig`. It goes away as soon as `rxLevel` drops below `rxTrig`.
- R8: While `rxLevel` is nonzero and `rxActivity` stays low, the timeout source becomes pending on the (4*CHAR_BITS+12)-th `bitTick`, which is the 52nd with defaults. It clears on `rbrRead` and does not fire again until activity or an empty FIFO restarts the count.
- R9: `txEmptyEvt` makes transmit empty pending. It clears on `thrWrite`, or on an `iirRead` in a cycle where `iirValue[5:0]` is 6'b000010. A read that reports any other code leaves it pending.
- R10: Any change of `modemLines` from its previous cycle makes modem status pending. `msrRead` clears it.
- R11: `xoffMatch` or `specialMatch` makes the Xoff/special source pending. After Xoff it clears on `xonMatch`, and after a special character it clears on `rxCharDone`. In both cases it also clears on an `iirRead` that reports 6'b010000.
- R12: A 0-to-1 change of `ctsIn` while `autoCtsEn` is 1, or of `rtsIn` while `autoRtsEn` is 1, makes the CTS/RTS source pending. Edges with the mode off are ignored. It clears on `msrRead` or on an `iirRead` that reports 6'b100000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fifoEn | input | 1 | FIFOs enabled, mirrored in bits 7:6 |
| srcEnable | input | 7 | Per-source enable mask |
| lineErr | input | 4 | Break, framing, parity, overrun flags present |
| lsrRead | input | 1 | Line status register read strobe |
| rxLevel | input | LVL_W | Receive FIFO occupancy |
| rxTrig | input | LVL_W | Receive trigger threshold |
| rxActivity | input | 1 | Receive FIFO push or pop strobe |
| bitTick | input | 1 | One pulse per bit time |
| rbrRead | input | 1 | Receive buffer read strobe |
| txEmptyEvt | input | 1 | Transmit holding register became empty |
| thrWrite | input | 1 | Transmit holding register write strobe |
| iirRead | input | 1 | Identification register read strobe |
| modemLines | input | 4 | Modem status input lines |
| msrRead | input | 1 | Modem status register read strobe |
| xoffMatch | input | 1 | Received character matched Xoff |
| specialMatch | input | 1 | Received character matched special character |
| xonMatch | input | 1 | Received character matched Xon |
| rxCharDone | input | 1 | A character was received |
| ctsIn | input | 1 | CTS pin level |
| rtsIn | input | 1 | RTS pin level |
| autoCtsEn | input | 1 | Automatic CTS flow control enabled |
| autoRtsEn | input | 1 | Automatic RTS flow control enabled |
| iirValue | output | 8 | Identification register value |
| irqOut | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a transmit-empty source that sits behind a more urgent source during an identification read. The bench sets the transmit-empty and line-error events together, reads while line status is reported, and then removes the line error. The transmit code must then come back before a second read clears it. The timeout needs a long run of bit ticks with occupancy below trigger and no activity. The bench counts out one tick short of the limit and then gives the last one. It then raises occupancy to the trigger to test the tie between timeout and data.

// File: rtl/uart_int_pkg.sv
package uart_int_pkg;
  localparam int NUM_SRC = 7;

  typedef enum logic [2:0] {
    SRC_LS = 3'd0,
    SRC_TO = 3'd1,
    SRC_RX = 3'd2,
    SRC_TX = 3'd3,
    SRC_MS = 3'd4,
    SRC_XO = 3'd5,
    SRC_FC = 3'd6
  } src_e;

  localparam logic [5:0] ID_LS   = 6'b000110;
  localparam logic [5:0] ID_TO   = 6'b001100;
  localparam logic [5:0] ID_RX   = 6'b000100;
  localparam logic [5:0] ID_TX   = 6'b000010;
  localparam logic [5:0] ID_MS   = 6'b000000;
  localparam logic [5:0] ID_XO   = 6'b010000;
  localparam logic [5:0] ID_FC   = 6'b100000;
  localparam logic [5:0] ID_NONE = 6'b000001;

  typedef struct packed {
    logic clrTx;
    logic clrXo;
    logic clrFc;
  } clr_t;
endpackage

// File: rtl/uart_int_dp.sv
module uart_int_dp
  import uart_int_pkg::*;
#(
  parameter int CHAR_BITS = 10,
  parameter int LVL_W = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  clr_t               clr,
  input  logic [3:0]         lineErr,
  input  logic               lsrRead,
  input  logic [LVL_W-1:0]   rxLevel,
  input  logic [LVL_W-1:0]   rxTrig,
  input  logic               rxActivity,
  input  logic               bitTick,
  input  logic               rbrRead,
  input  logic               txEmptyEvt,
  input  logic               thrWrite,
  input  logic [3:0]         modemLines,
  input  logic               msrRead,
  input  logic               xoffMatch,
  input  logic               specialMatch,
  input  logic               xonMatch,
  input  logic               rxCharDone,
  input  logic               ctsIn,
  input  logic               rtsIn,
  input  logic               autoCtsEn,
  input  logic               autoRtsEn,
  output logic [NUM_SRC-1:0] pend
);
  localparam int TO_BITS = 4 * CHAR_BITS + 12;
  localparam int TO_W = $clog2(TO_BITS + 1);

  logic lsPend, toPend, txPend, msPend, xoPend, xoIsSpecial, fcPend;
  logic [TO_W-1:0] toCnt;
  logic [3:0] prevModem;
  logic prevCts, prevRts;

  logic rxEmpty, toHit, msChange, ctsRise, rtsRise, fcSet, xoSet, xoClr;

  assign rxEmpty  = (rxLevel == '0);
  assign toHit    = bitTick && !rxActivity && !rxEmpty && (toCnt == TO_W'(TO_BITS - 1));
  assign msChange = (modemLines != prevModem);
  assign ctsRise  = ctsIn && !prevCts && autoCtsEn;
  assign rtsRise  = rtsIn && !prevRts && autoRtsEn;
  assign fcSet    = ctsRise || rtsRise;
  assign xoSet    = xoffMatch || specialMatch;
  assign xoClr    = clr.clrXo || (xoIsSpecial ? rxCharDone : xonMatch);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      toCnt <= '0;
    end else if (rxActivity || rxEmpty) begin
      toCnt <= '0;
    end else if (bitTick && toCnt != TO_W'(TO_BITS)) begin
      toCnt <= toCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lsPend      <= 1'b0;
      toPend      <= 1'b0;
      txPend      <= 1'b0;
      msPend      <= 1'b0;
      xoPend      <= 1'b0;
      xoIsSpecial <= 1'b0;
      fcPend      <= 1'b0;
      prevModem   <= '0;
      prevCts     <= 1'b0;
      prevRts     <= 1'b0;
    end else begin
      lsPend    <= (|lineErr) || (lsPend && !lsrRead);
      toPend    <= toHit || (toPend && !rbrRead);
      txPend    <= txEmptyEvt || (txPend && !thrWrite && !clr.clrTx);
      msPend    <= msChange || (msPend && !msrRead);
      xoPend    <= xoSet || (xoPend && !xoClr);
      if (xoSet) xoIsSpecial <= specialMatch && !xoffMatch;
      fcPend    <= fcSet || (fcPend && !msrRead && !clr.clrFc);
      prevModem <= modemLines;
      prevCts   <= ctsIn;
      prevRts   <= rtsIn;
    end
  end

  always_comb begin
    pend         = '0;
    pend[SRC_LS] = lsPend;
    pend[SRC_TO] = toPend;
    pend[SRC_RX] = !rxEmpty && (rxLevel >= rxTrig);
    pend[SRC_TX] = txPend;
    pend[SRC_MS] = msPend;
    pend[SRC_XO] = xoPend;
    pend[SRC_FC] = fcPend;
  end

  a_r6_line_err_sets: assert property (@(posedge clk) disable iff (!rstN)
    (|lineErr) |=> pend[SRC_LS]);
  a_r6_line_err_blocks_clear: assert property (@(posedge clk) disable iff (!rstN)
    (pend[SRC_LS] && lsrRead && (|lineErr)) |=> pend[SRC_LS]);
  a_r9_thr_write_clears: assert property (@(posedge clk) disable iff (!rstN)
    (thrWrite && !txEmptyEvt) |=> !pend[SRC_TX]);
  a_r10_modem_change: assert property (@(posedge clk) disable iff (!rstN)
    (modemLines != prevModem) |=> pend[SRC_MS]);
  a_r12_cts_edge: assert property (@(posedge clk) disable iff (!rstN)
    (autoCtsEn && $rose(ctsIn)) |=> pend[SRC_FC]);
  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    toCnt <= TO_W'(TO_BITS));
endmodule

// File: rtl/uart_int_ctrl.sv
module uart_int_ctrl
  import uart_int_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] pend,
  input  logic [NUM_SRC-1:0] srcEnable,
  input  logic               fifoEn,
  input  logic               iirRead,
  output logic [7:0]         iirValue,
  output logic               irqOut,
  output clr_t               clr
);
  logic [NUM_SRC-1:0] active;
  logic [5:0] idCode;

  assign active = pend & srcEnable;

  always_comb begin
    if (active[SRC_LS])      idCode = ID_LS;
    else if (active[SRC_TO]) idCode = ID_TO;
    else if (active[SRC_RX]) idCode = ID_RX;
    else if (active[SRC_TX]) idCode = ID_TX;
    else if (active[SRC_MS]) idCode = ID_MS;
    else if (active[SRC_XO]) idCode = ID_XO;
    else if (active[SRC_FC]) idCode = ID_FC;
    else                     idCode = ID_NONE;
  end

  assign iirValue  = {{2{fifoEn}}, idCode};
  assign irqOut    = !idCode[0];
  assign clr.clrTx = iirRead && (idCode == ID_TX);
  assign clr.clrXo = iirRead && (idCode == ID_XO);
  assign clr.clrFc = iirRead && (idCode == ID_FC);

  a_r1_idle_flag: assert property (@(posedge clk) disable iff (!rstN)
    ((pend & srcEnable) == '0) |-> (iirValue[0] && !irqOut));
  a_r5_masked_quiet: assert property (@(posedge clk) disable iff (!rstN)
    ((pend & srcEnable) == '0) |-> (iirValue[5:0] == ID_NONE));
  a_r4_line_first: assert property (@(posedge clk) disable iff (!rstN)
    (pend[SRC_LS] && srcEnable[SRC_LS]) |-> (iirValue[5:0] == ID_LS));
endmodule

// File: rtl/uart_int_ident.sv
module uart_int_ident
  import uart_int_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int CHAR_BITS = 10,
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fifoEn,
  input  logic [6:0]       srcEnable,
  input  logic [3:0]       lineErr,
  input  logic             lsrRead,
  input  logic [LVL_W-1:0] rxLevel,
  input  logic [LVL_W-1:0] rxTrig,
  input  logic             rxActivity,
  input  logic             bitTick,
  input  logic             rbrRead,
  input  logic             txEmptyEvt,
  input  logic             thrWrite,
  input  logic             iirRead,
  input  logic [3:0]       modemLines,
  input  logic             msrRead,
  input  logic             xoffMatch,
  input  logic             specialMatch,
  input  logic             xonMatch,
  input  logic             rxCharDone,
  input  logic             ctsIn,
  input  logic             rtsIn,
  input  logic             autoCtsEn,
  input  logic             autoRtsEn,
  output logic [7:0]       iirValue,
  output logic             irqOut
);
  logic [NUM_SRC-1:0] pend;
  clr_t clr;

  uart_int_dp #(.CHAR_BITS(CHAR_BITS), .LVL_W(LVL_W)) i_dp (
    .clk(clk), .rstN(rstN), .clr(clr),
    .lineErr(lineErr), .lsrRead(lsrRead),
    .rxLevel(rxLevel), .rxTrig(rxTrig), .rxActivity(rxActivity),
    .bitTick(bitTick), .rbrRead(rbrRead),
    .txEmptyEvt(txEmptyEvt), .thrWrite(thrWrite),
    .modemLines(modemLines), .msrRead(msrRead),
    .xoffMatch(xoffMatch), .specialMatch(specialMatch),
    .xonMatch(xonMatch), .rxCharDone(rxCharDone),
    .ctsIn(ctsIn), .rtsIn(rtsIn), .autoCtsEn(autoCtsEn), .autoRtsEn(autoRtsEn),
    .pend(pend)
  );

  uart_int_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .pend(pend), .srcEnable(srcEnable),
    .fifoEn(fifoEn), .iirRead(iirRead),
    .iirValue(iirValue), .irqOut(irqOut), .clr(clr)
  );

  a_r9_tx_kept: assert property (@(posedge clk) disable iff (!rstN)
    (iirRead && pend[SRC_TX] && iirValue[5:0] != ID_TX && !thrWrite) |=> pend[SRC_TX]);
endmodule

// File: tb/test_uart_int_ident.sv
module test_uart_int_ident;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fifoEn = 1'b0;
  logic [6:0] srcEnable = 7'h7F;
  logic [3:0] lineErr = '0;
  logic lsrRead = 1'b0;
  logic [6:0] rxLevel = '0;
  logic [6:0] rxTrig = 7'd4;
  logic rxActivity = 1'b0, bitTick = 1'b0, rbrRead = 1'b0;
  logic txEmptyEvt = 1'b0, thrWrite = 1'b0, iirRead = 1'b0;
  logic [3:0] modemLines = '0;
  logic msrRead = 1'b0, xoffMatch = 1'b0, specialMatch = 1'b0, xonMatch = 1'b0;
  logic rxCharDone = 1'b0, ctsIn = 1'b0, rtsIn = 1'b0, autoCtsEn = 1'b0, autoRtsEn = 1'b0;
  logic [7:0] iirValue;
  logic irqOut;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  localparam int TO_TICKS = 4 * 10 + 12;

  always #5 clk = ~clk;

  uart_int_ident i_uart_int_ident (
    .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .srcEnable(srcEnable),
    .lineErr(lineErr), .lsrRead(lsrRead), .rxLevel(rxLevel), .rxTrig(rxTrig),
    .rxActivity(rxActivity), .bitTick(bitTick), .rbrRead(rbrRead),
    .txEmptyEvt(txEmptyEvt), .thrWrite(thrWrite), .iirRead(iirRead),
    .modemLines(modemLines), .msrRead(msrRead), .xoffMatch(xoffMatch),
    .specialMatch(specialMatch), .xonMatch(xonMatch), .rxCharDone(rxCharDone),
    .ctsIn(ctsIn), .rtsIn(rtsIn), .autoCtsEn(autoCtsEn), .autoRtsEn(autoRtsEn),
    .iirValue(iirValue), .irqOut(irqOut)
  );

  task automatic chk(input string req, input logic [7:0] exp);
    checks++;
    if (iirValue !== exp || irqOut !== !exp[0]) begin
      fails++;
      $display("FAIL %s: iir=%h irq=%b expected iir=%h irq=%b", req, iirValue, irqOut, exp, !exp[0]);
    end
  endtask

  task automatic stepIir();
    @(negedge clk) iirRead = 1'b1;
    @(negedge clk) iirRead = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reset", 8'h01);
    fifoEn = 1'b1;
    @(negedge clk) chk("R2 fifo on", 8'hC1);
    fifoEn = 1'b0;
    @(negedge clk) chk("R2 fifo off", 8'h01);
  endtask

  task automatic t_line();
    lineErr = 4'b0010;
    @(negedge clk) chk("R6 R3 line set", 8'h06);
    lsrRead = 1'b1;
    @(negedge clk) lsrRead = 1'b0;
    chk("R6 read with error left", 8'h06);
    lineErr = '0;
    @(negedge clk) chk("R6 no read yet", 8'h06);
    lsrRead = 1'b1;
    @(negedge clk) lsrRead = 1'b0;
    chk("R6 cleared", 8'h01);
  endtask

  task automatic t_rx();
    rxLevel = 7'd4;
    @(negedge clk) chk("R7 R3 at trigger", 8'h04);
    rxLevel = 7'd3;
    @(negedge clk) chk("R7 below trigger", 8'h01);
  endtask

  task automatic t_timeout();
    rxLevel = 7'd1;
    for (int i = 0; i < TO_TICKS - 1; i++) begin
      @(negedge clk) bitTick = 1'b1;
      @(negedge clk) bitTick = 1'b0;
    end
    chk("R8 one tick short", 8'h01);
    @(negedge clk) bitTick = 1'b1;
    @(negedge clk) bitTick = 1'b0;
    chk("R8 R3 timeout", 8'h0C);
    rxLevel = 7'd4;
    @(negedge clk) chk("R4 timeout over data", 8'h0C);
    rbrRead = 1'b1;
    @(negedge clk) rbrRead = 1'b0;
    chk("R8 cleared by rbr read", 8'h04);
    rxLevel = '0;
    @(negedge clk) chk("R7 empty", 8'h01);
  endtask

  task automatic t_tx();
    @(negedge clk) txEmptyEvt = 1'b1;
    @(negedge clk) txEmptyEvt = 1'b0;
    chk("R9 R3 tx empty", 8'h02);
    stepIir();
    chk("R9 cleared by iir read", 8'h01);
    @(negedge clk) txEmptyEvt = 1'b1;
    @(negedge clk) txEmptyEvt = 1'b0;
    thrWrite = 1'b1;
    @(negedge clk) thrWrite = 1'b0;
    chk("R9 cleared by thr write", 8'h01);
    txEmptyEvt = 1'b1;
    lineErr = 4'b0001;
    @(negedge clk) txEmptyEvt = 1'b0;
    chk("R4 line over tx", 8'h06);
    stepIir();
    lineErr = '0;
    lsrRead = 1'b1;
    @(negedge clk) lsrRead = 1'b0;
    chk("R9 tx kept after other read", 8'h02);
    stepIir();
    chk("R9 tx cleared", 8'h01);
  endtask

  task automatic t_modem();
    modemLines = 4'b0100;
    @(negedge clk) chk("R10 R3 modem change", 8'h00);
    msrRead = 1'b1;
    @(negedge clk) msrRead = 1'b0;
    chk("R10 cleared", 8'h01);
    modemLines = '0;
    @(negedge clk) chk("R10 change back", 8'h00);
    msrRead = 1'b1;
    @(negedge clk) msrRead = 1'b0;
    chk("R10 cleared again", 8'h01);
  endtask

  task automatic t_xoff();
    @(negedge clk) xoffMatch = 1'b1;
    @(negedge clk) xoffMatch = 1'b0;
    chk("R11 R3 xoff", 8'h10);
    rxCharDone = 1'b1;
    @(negedge clk) rxCharDone = 1'b0;
    chk("R11 xoff kept on plain char", 8'h10);
    xonMatch = 1'b1;
    @(negedge clk) xonMatch = 1'b0;
    chk("R11 xon clears", 8'h01);
    specialMatch = 1'b1;
    @(negedge clk) specialMatch = 1'b0;
    chk("R11 special", 8'h10);
    rxCharDone = 1'b1;
    @(negedge clk) rxCharDone = 1'b0;
    chk("R11 next char clears", 8'h01);
    specialMatch = 1'b1;
    @(negedge clk) specialMatch = 1'b0;
    stepIir();
    chk("R11 iir read clears", 8'h01);
  endtask

  task automatic t_flow();
    @(negedge clk) ctsIn = 1'b1;
    @(negedge clk) chk("R12 edge ignored when off", 8'h01);
    ctsIn = 1'b0;
    autoCtsEn = 1'b1;
    @(negedge clk) ctsIn = 1'b1;
    @(negedge clk) chk("R12 R3 cts edge", 8'h20);
    stepIir();
    chk("R12 iir read clears", 8'h01);
    ctsIn = 1'b0;
    autoCtsEn = 1'b0;
    autoRtsEn = 1'b1;
    @(negedge clk) rtsIn = 1'b1;
    @(negedge clk) chk("R12 rts edge", 8'h20);
    msrRead = 1'b1;
    @(negedge clk) msrRead = 1'b0;
    chk("R12 msr read clears", 8'h01);
    rtsIn = 1'b0;
    autoRtsEn = 1'b0;
  endtask

  task automatic t_priority();
    @(negedge clk) begin
      modemLines = 4'b0001;
      xoffMatch = 1'b1;
      txEmptyEvt = 1'b1;
      autoCtsEn = 1'b1;
      ctsIn = 1'b1;
    end
    @(negedge clk) begin
      xoffMatch = 1'b0;
      txEmptyEvt = 1'b0;
    end
    chk("R4 tx first", 8'h02);
    stepIir();
    chk("R4 modem next", 8'h00);
    modemLines = '0;
    @(negedge clk) msrRead = 1'b1;
    @(negedge clk) msrRead = 1'b0;
    chk("R4 xoff after modem, cts cleared by msr", 8'h10);
    stepIir();
    chk("R4 all clear", 8'h01);
    ctsIn = 1'b0;
    autoCtsEn = 1'b0;
  endtask

  task automatic t_mask();
    srcEnable = 7'b1110111;
    @(negedge clk) txEmptyEvt = 1'b1;
    @(negedge clk) txEmptyEvt = 1'b0;
    chk("R5 masked tx hidden", 8'h01);
    srcEnable = 7'h7F;
    @(negedge clk) chk("R5 unmasked tx shows", 8'h02);
    stepIir();
    chk("R5 cleared", 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_line();
    t_rx();
    t_timeout();
    t_tx();
    t_modem();
    t_xoff();
    t_flow();
    t_priority();
    t_mask();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule